// File: doc/BRIEF.md
# Three-Transistor Dynamic Cell Array Controller

This block sequences host accesses and background refresh for a small array of three-transistor dynamic storage cells. Each cell has two word lines and two bit lines: one pair for writing and one pair for reading. The array is modelled in synthesizable logic. A read precharges a shared read bit line high, and a stored 1 then discharges it, so the raw sensed value is the complement of the stored row. The controller undoes this inversion before returning data. It also undoes it when it rewrites a row during refresh.

Hosts issue whole-row reads and writes on a valid/ready request channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle and no refresh is waiting, so a host holds its request, with its fields stable, until it is taken. Read data returns on a one-cycle `rsp_valid` pulse, and that response path has no back-pressure. Every access follows the same phase order: precharge, read word line, sample, and then, for writes and refreshes only, write word line. A free-running timer divides the refresh interval evenly among the rows. Each time a row slot expires, the next row in round-robin order is read and rewritten with the inverse of its sensed bit line.

Top module: `dram3t_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and all three phase outputs are 0, and every row reads back as all zeros.
- R2: A read of a row returns exactly the data last written to that row (not the inverted bit-line value), for any data pattern.
- R3: A read accepted on clock edge E shows precharge in the cycle after E, the read word line in the next cycle, no active phase and no response in the third cycle, and `rsp_valid` high for exactly one cycle in the fourth cycle.
- R4: A write accepted on edge E follows the same first three cycles as a read, then asserts the write word line for exactly one cycle in the fourth cycle after E, and returns no response.
- R5: Reads are non-destructive: reading the same row several times in a row returns the same data each time.
- R6: The read word line and the write word line are never high in the same cycle, and the read word line is always directly preceded by a precharge cycle.
- R7: Refresh operations start once per REFRESH_CYCLES/ROWS cycles on average, each start is delayed by at most one access length, and the rows are refreshed in the order 0, 1, …, ROWS-1, then repeating, as shown on `phase_row` while `refresh_busy` is high.
- R8: A due refresh takes priority over a waiting host request: `req_ready` is low whenever a refresh is pending or `refresh_busy` is high.
- R9: Refresh preserves stored data: after many full refresh rounds with no host writes, every row still reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write row, 0 = read row |
| req_addr | input | $clog2(ROWS) | Row address |
| req_wdata | input | COLS | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | COLS | Read data, same polarity as written |
| phase_precharge | output | 1 | Read bit line precharge phase |
| phase_read_wl | output | 1 | Read word line active |
| phase_write_wl | output | 1 | Write word line active |
| phase_row | output | $clog2(ROWS) | Row under access |
| refresh_busy | output | 1 | Current access is a refresh |

## Verification
The assertions assume that ROWS is a power of two and that the per-row refresh spacing is much longer than the five-cycle worst-case access, so a refresh slot never expires while the previous one is still pending. The bench builds a four-row, 8-bit configuration with a 40-cycle slot. In that setup every access ends well inside one slot. Host requests are driven only at falling edges, and their fields are held until the request is accepted.

// File: rtl/dram3t_pkg.sv
package dram3t_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RWL,
    ST_SAMP,
    ST_WWL
  } phase_e;

  typedef enum logic [1:0] {
    OP_READ,
    OP_WRITE,
    OP_REFRESH
  } op_e;
endpackage

// File: rtl/dram3t_cells.sv
module dram3t_cells #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prech,
  input  logic            rd_wl,
  input  logic            wr_wl,
  input  logic [AW-1:0]   row,
  input  logic [COLS-1:0] wbl,
  output logic [COLS-1:0] rbl
);
  logic [COLS-1:0] mem [ROWS];

  // Read bit line: charged high, then discharged by every stored 1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbl <= '1;
    end else if (prech) begin
      rbl <= '1;
    end else if (rd_wl) begin
      rbl <= rbl & ~mem[row];
    end
  end

  // Storage nodes: take the write bit line while the write word line is up.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (wr_wl) begin
      mem[row] <= wbl;
    end
  end

  AST_WL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_wl && wr_wl)); // R6
  AST_RWL_AFTER_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wl |-> $past(prech)); // R6
endmodule

// File: rtl/dram3t_refresh.sv
module dram3t_refresh #(
  parameter int ROWS = 16,
  parameter int REFRESH_CYCLES = 200000,
  localparam int AW  = $clog2(ROWS),
  localparam int GAP = REFRESH_CYCLES / ROWS,
  localparam int CW  = $clog2(GAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_take,
  output logic          ref_pending,
  output logic [AW-1:0] ref_row
);
  localparam logic [CW-1:0] LAST    = CW'(GAP - 1);
  localparam logic [AW-1:0] ROW_MAX = AW'(ROWS - 1);

  logic [CW-1:0] cnt;
  logic          slot_end;

  assign slot_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (slot_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_pending <= 1'b0;
    end else if (slot_end) begin
      ref_pending <= 1'b1;
    end else if (ref_take) begin
      ref_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_row <= '0;
    end else if (ref_take) begin
      ref_row <= (ref_row == ROW_MAX) ? '0 : ref_row + 1'b1;
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> !ref_pending); // R7
  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ref_take |-> ref_pending); // R7
endmodule

// File: rtl/dram3t_seq.sv
module dram3t_seq
  import dram3t_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [COLS-1:0] req_wdata,
  output logic            req_ready,
  input  logic            ref_pending,
  input  logic [AW-1:0]   ref_row,
  output logic            ref_take,
  output logic            rsp_valid,
  output logic [COLS-1:0] rsp_rdata,
  output logic            prech,
  output logic            rd_wl,
  output logic            wr_wl,
  output logic [AW-1:0]   row,
  output logic [COLS-1:0] wbl,
  output logic            ref_busy,
  input  logic [COLS-1:0] rbl
);
  phase_e          st;
  op_e             op;
  logic [AW-1:0]   row_q;
  logic [COLS-1:0] wdata_q;
  logic [COLS-1:0] sense_q;
  logic            idle;

  assign idle      = (st == ST_IDLE);
  assign ref_take  = idle && ref_pending;
  assign req_ready = idle && !ref_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op      <= OP_READ;
      row_q   <= '0;
      wdata_q <= '0;
      sense_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (ref_take) begin
            st    <= ST_PRE;
            op    <= OP_REFRESH;
            row_q <= ref_row;
          end else if (req_valid) begin
            st      <= ST_PRE;
            op      <= req_write ? OP_WRITE : OP_READ;
            row_q   <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        ST_PRE:  st <= ST_RWL;
        ST_RWL:  st <= ST_SAMP;
        ST_SAMP: begin
          sense_q <= rbl;
          st      <= (op == OP_READ) ? ST_IDLE : ST_WWL;
        end
        ST_WWL:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Host data leaves with the bit-line inversion undone.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st == ST_SAMP) && (op == OP_READ);
      if ((st == ST_SAMP) && (op == OP_READ)) rsp_rdata <= ~rbl;
    end
  end

  assign prech    = (st == ST_PRE);
  assign rd_wl    = (st == ST_RWL);
  assign wr_wl    = (st == ST_WWL);
  assign row      = row_q;
  assign wbl      = (op == OP_REFRESH) ? ~sense_q : wdata_q;
  assign ref_busy = !idle && (op == OP_REFRESH);

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(row_q)); // R3
  AST_WWL_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wl |-> $past(st == ST_SAMP)); // R4
  AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wl |-> !rsp_valid); // R4
  AST_READY_LOW_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !req_ready); // R8
endmodule

// File: rtl/dram3t_ctrl.sv
module dram3t_ctrl #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int REFRESH_CYCLES = 200000,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [COLS-1:0] req_wdata,
  output logic            rsp_valid,
  output logic [COLS-1:0] rsp_rdata,
  output logic            phase_precharge,
  output logic            phase_read_wl,
  output logic            phase_write_wl,
  output logic [AW-1:0]   phase_row,
  output logic            refresh_busy
);
  logic            ref_pending;
  logic            ref_take;
  logic [AW-1:0]   ref_row;
  logic [COLS-1:0] wbl;
  logic [COLS-1:0] rbl;

  dram3t_refresh #(.ROWS(ROWS), .REFRESH_CYCLES(REFRESH_CYCLES)) u_refresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_take    (ref_take),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dram3t_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_take    (ref_take),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .prech       (phase_precharge),
    .rd_wl       (phase_read_wl),
    .wr_wl       (phase_write_wl),
    .row         (phase_row),
    .wbl         (wbl),
    .ref_busy    (refresh_busy),
    .rbl         (rbl)
  );

  dram3t_cells #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk   (clk),
    .rst_n (rst_n),
    .prech (phase_precharge),
    .rd_wl (phase_read_wl),
    .wr_wl (phase_write_wl),
    .row   (phase_row),
    .wbl   (wbl),
    .rbl   (rbl)
  );

  AST_PENDING_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !req_ready); // R8
endmodule

// File: tb/tb_dram3t_ctrl.sv
module tb_dram3t_ctrl;
  localparam int ROWS = 4;
  localparam int COLS = 8;
  localparam int REFRESH_CYCLES = 160;
  localparam int GAP = REFRESH_CYCLES / ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, phase_precharge, phase_read_wl, phase_write_wl, refresh_busy;
  logic [7:0] rsp_rdata;
  logic [1:0] phase_row;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_mem [ROWS];

  always #5 clk = ~clk;

  dram3t_ctrl #(.ROWS(ROWS), .COLS(COLS), .REFRESH_CYCLES(REFRESH_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .phase_precharge(phase_precharge), .phase_read_wl(phase_read_wl),
    .phase_write_wl(phase_write_wl), .phase_row(phase_row), .refresh_busy(refresh_busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int p, int r);
    if (p == 0) return 8'h00;
    if (p == 1) return 8'hFF;
    return 8'((p * 37 + r * 11 + 8'h5A) ^ (p << 4));
  endfunction

  task automatic host_op(input bit wr, input int a, input logic [7:0] d, output logic [7:0] q);
    q = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 2'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(phase_precharge == 1'b1 && phase_row == 2'(a), wr ? "R4 precharge" : "R3 precharge",
          phase_precharge, 1);
    @(negedge clk);
    check(phase_read_wl == 1'b1, wr ? "R4 read wl" : "R3 read wl", phase_read_wl, 1);
    @(negedge clk);
    check(!phase_read_wl && !phase_write_wl && !rsp_valid, "R3 sample cycle quiet",
          {phase_read_wl, phase_write_wl, rsp_valid}, 0);
    @(negedge clk);
    if (wr) begin
      check(phase_write_wl == 1'b1 && !rsp_valid, "R4 write wl", {phase_write_wl, rsp_valid}, 2);
      exp_mem[a] = d;
      @(negedge clk);
      check(phase_write_wl == 1'b0, "R4 write wl single cycle", phase_write_wl, 0);
    end else begin
      check(rsp_valid == 1'b1, "R3 rsp_valid", rsp_valid, 1);
      q = rsp_rdata;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R3 rsp_valid single cycle", rsp_valid, 0);
    end
  endtask

  // Monitors for R6, R7 and R8.
  int ref_starts = 0;
  int exp_ref_row = 0;
  int last_start = -1;
  int cyc = 0;
  bit prev_busy = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (phase_read_wl && phase_write_wl) check(1'b0, "R6 word lines overlap", 1, 0);
      if (refresh_busy && req_ready) check(1'b0, "R8 ready during refresh", 1, 0);
      if (refresh_busy && !prev_busy) begin
        check(phase_row == 2'(exp_ref_row), "R7 refresh row order", phase_row, exp_ref_row);
        if (last_start >= 0)
          check((cyc - last_start) >= GAP - 6 && (cyc - last_start) <= GAP + 6,
                "R7 refresh spacing", cyc - last_start, GAP);
        last_start = cyc;
        exp_ref_row = (exp_ref_row + 1) % ROWS;
        ref_starts++;
      end
      prev_busy = refresh_busy;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] q0;
    int starts0;
    for (int i = 0; i < ROWS; i++) exp_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(!rsp_valid && !phase_precharge && !phase_read_wl && !phase_write_wl,
          "R1 outputs idle", {rsp_valid, phase_precharge, phase_read_wl, phase_write_wl}, 0);
    for (int r = 0; r < ROWS; r++) begin
      host_op(1'b0, r, 8'h00, q);
      check(q == 8'h00, "R1 row zero after reset", q, 0);
    end

    // R2 sweep of patterns over every row
    for (int p = 0; p < 6; p++) begin
      for (int r = 0; r < ROWS; r++) host_op(1'b1, r, pat(p, r), q);
      for (int r = 0; r < ROWS; r++) begin
        host_op(1'b0, r, 8'h00, q);
        check(q == pat(p, r), "R2 read returns written data", q, pat(p, r));
      end
    end

    // R5 repeated reads
    host_op(1'b1, 2, 8'hC3, q);
    host_op(1'b0, 2, 8'h00, q0);
    for (int k = 0; k < 4; k++) begin
      host_op(1'b0, 2, 8'h00, q);
      check(q == q0 && q == 8'hC3, "R5 non-destructive read", q, 8'hC3);
    end

    // R9 retention across many refresh rounds; R7 refresh rate
    for (int r = 0; r < ROWS; r++) host_op(1'b1, r, pat(7, r), q);
    starts0 = ref_starts;
    repeat (5 * REFRESH_CYCLES) @(negedge clk);
    check((ref_starts - starts0) >= 19 && (ref_starts - starts0) <= 21,
          "R7 refresh count in window", ref_starts - starts0, 20);
    for (int r = 0; r < ROWS; r++) begin
      host_op(1'b0, r, 8'h00, q);
      check(q == exp_mem[r], "R9 data kept by refresh", q, exp_mem[r]);
    end

    // R8 request waiting while a refresh runs
    while (!refresh_busy) @(negedge clk);
    check(req_ready == 1'b0, "R8 ready low at refresh", req_ready, 0);
    host_op(1'b0, 1, 8'h00, q);
    check(q == exp_mem[1], "R8 delayed read data", q, exp_mem[1]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule